// File: doc/BRIEF.md
# Seven-to-One Parallel Video Serializer

This block takes a 28-bit pixel word on every pixel-clock cycle and turns it into four serial data lanes, each carrying seven bits per pixel period, plus a fifth lane that carries a forwarded clock pattern. The clock lane is framed exactly like the data lanes, so a receiver can use its edges to find word boundaries. The usual payload is 24 colour bits, three display timing bits (line sync, frame sync and data valid) and one spare bit. The block does not interpret the payload. It only decides where each bit appears on the lanes.

The block models the digital side of the transmitter. An input capture register runs on a pin-selected edge of the pixel clock. A holding register carries each word into the seven-times fast clock domain. Five shift registers move the bits out, least significant bit first. An external 7x clock and a frame strobe that pulses once every seven fast cycles stand in for the phase-locked loop. A power-down input silences every lane, the clock lane included.

Top module: `pix_serializer`

## Requirements
- R1: While `rst_n` is low, every data lane and the clock lane are low, and this takes effect at once, without waiting for a clock edge.
- R2: With `fall_edge` = 0 the input word is captured on the rising edge of `pix_clk`. With `fall_edge` = 1 it is captured on the falling edge.
- R3: Data lane k carries the captured bits `pix_data[7k+6:7k]`, where lane k is output bit k of `lane_q`.
- R4: A frame load happens at the `fast_clk` edge where `frame_strb` is sampled high. Bit j of a lane's 7-bit slice appears in the j-th fast cycle after that edge (j = 0 to 6), least significant bit first.
- R5: Every frame load restarts the clock lane, which then sends the sequence 1,1,0,0,0,1,1 over the seven fast cycles.
- R6: All four data lanes and the clock lane load on the same fast edge, so all of them carry slices of the same pixel word.
- R7: The word held for the fast domain updates only in the fast cycle just before a frame load. A frame therefore carries the word captured before that cycle.
- R8: Once `pwr_dn` is sampled high by `fast_clk`, all five lanes read low from the next fast cycle on, and they stay low for as long as `pwr_dn` stays high.
- R9: After `pwr_dn` falls, the lanes stay low until the next frame load. From that load a full frame is sent, carrying the current pixel word and the clock pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Pixel clock |
| fast_clk | input | 1 | Bit clock, seven times the pixel rate, phase-related to `pix_clk` |
| rst_n | input | 1 | Asynchronous active-low reset |
| fall_edge | input | 1 | Static capture edge select: 0 rising, 1 falling |
| pwr_dn | input | 1 | Power-down, active high |
| frame_strb | input | 1 | One-cycle pulse every seven `fast_clk` cycles that marks a frame load |
| pix_data | input | 28 | Parallel pixel word |
| lane_q | output | 4 | Serial data lanes, bit k is lane k |
| clk_lane_q | output | 1 | Forwarded clock lane |

## Verification
The hardest case to reach from the ports is the one that tells the two capture edges apart. The pixel word must change between a rising and a falling pixel-clock edge that both come before the holding update. Only then does the next frame show whether the old word or the new one crossed into the fast domain. The bench derives both clocks and the strobe from fixed offsets so it knows those edge times exactly. It changes the word three fast cycles after a frame load and expects the old word in rising mode and the new one in falling mode. The power-down release is also placed with care: it comes just after a suppressed load, so that six empty bit slots can be seen before the first full frame.

// File: rtl/pix_serializer.sv
module pix_serializer #(
  parameter int LANES = 4,
  parameter int BITS = 7,
  parameter logic [BITS-1:0] CLK_PAT = 7'b1100011
) (
  input  logic                    pix_clk,
  input  logic                    fast_clk,
  input  logic                    rst_n,
  input  logic                    fall_edge,
  input  logic                    pwr_dn,
  input  logic                    frame_strb,
  input  logic [LANES*BITS-1:0]   pix_data,
  output logic [LANES-1:0]        lane_q,
  output logic                    clk_lane_q
);
  localparam int W  = LANES * BITS;
  localparam int CW = $clog2(BITS);

  logic [W-1:0]    cap_r, cap_f, hold_q;
  logic [CW-1:0]   phase_q;
  logic [BITS-1:0] ck_sh;

  wire load    = frame_strb & ~pwr_dn;
  wire hold_en = (phase_q == CW'(BITS - 1)) & ~pwr_dn;

  always_ff @(posedge pix_clk or negedge rst_n)
    if (!rst_n)      cap_r <= '0;
    else if (pwr_dn) cap_r <= '0;
    else             cap_r <= pix_data;

  always_ff @(negedge pix_clk or negedge rst_n)
    if (!rst_n)      cap_f <= '0;
    else if (pwr_dn) cap_f <= '0;
    else             cap_f <= pix_data;

  always_ff @(posedge fast_clk or negedge rst_n)
    if (!rst_n)                         phase_q <= '0;
    else if (frame_strb)                phase_q <= CW'(1);
    else if (phase_q == CW'(BITS - 1))  phase_q <= '0;
    else                                phase_q <= phase_q + CW'(1);

  always_ff @(posedge fast_clk or negedge rst_n)
    if (!rst_n)       hold_q <= '0;
    else if (pwr_dn)  hold_q <= '0;
    else if (hold_en) hold_q <= fall_edge ? cap_f : cap_r;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [BITS-1:0] sh_q;
    always_ff @(posedge fast_clk or negedge rst_n)
      if (!rst_n)      sh_q <= '0;
      else if (pwr_dn) sh_q <= '0;
      else if (load)   sh_q <= hold_q[k*BITS +: BITS];
      else             sh_q <= {1'b0, sh_q[BITS-1:1]};
    assign lane_q[k] = sh_q[0];
  end

  always_ff @(posedge fast_clk or negedge rst_n)
    if (!rst_n)      ck_sh <= '0;
    else if (pwr_dn) ck_sh <= '0;
    else if (load)   ck_sh <= CLK_PAT;
    else             ck_sh <= {1'b0, ck_sh[BITS-1:1]};

  assign clk_lane_q = ck_sh[0];
endmodule

module pix_serializer_chk #(
  parameter int LANES = 4,
  parameter int BITS = 7,
  parameter logic [BITS-1:0] CLK_PAT = 7'b1100011
) (
  input logic                  fast_clk,
  input logic                  rst_n,
  input logic                  pwr_dn,
  input logic                  frame_strb,
  input logic [LANES-1:0]      lane_q,
  input logic                  clk_lane_q,
  input logic [LANES*BITS-1:0] hold_q
);
  logic seen_q;
  always_ff @(posedge fast_clk or negedge rst_n)
    if (!rst_n)          seen_q <= 1'b0;
    else if (frame_strb) seen_q <= 1'b1;

  p_pd_quiet_r8: assert property (@(posedge fast_clk) disable iff (!rst_n)
    pwr_dn |=> (lane_q == '0) && !clk_lane_q);

  p_clk_first_r5: assert property (@(posedge fast_clk) disable iff (!rst_n)
    (frame_strb && !pwr_dn) |=> clk_lane_q == CLK_PAT[0]);

  for (genvar k = 0; k < LANES; k++) begin : g_map
    p_lane_map_r3: assert property (@(posedge fast_clk) disable iff (!rst_n)
      (frame_strb && !pwr_dn) |=> lane_q[k] == $past(hold_q[k*BITS]));
  end

  p_hold_timing_r7: assert property (@(posedge fast_clk) disable iff (!rst_n)
    (seen_q && !pwr_dn && !$past(pwr_dn) && hold_q != $past(hold_q)) |-> frame_strb);
endmodule

bind pix_serializer pix_serializer_chk #(.LANES(LANES), .BITS(BITS), .CLK_PAT(CLK_PAT)) chk_i (
  .fast_clk(fast_clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .frame_strb(frame_strb),
  .lane_q(lane_q), .clk_lane_q(clk_lane_q), .hold_q(hold_q));

// File: tb/pix_serializer_tb_top.sv
module pix_serializer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] CK_SEQ = 7'b1100011;

  logic pix_clk, fast_clk, rst_n, fall_edge, pwr_dn, frame_strb;
  logic [27:0] pix_data;
  logic [3:0]  lane_q;
  logic        clk_lane_q;
  int n_cmp = 0, n_bad = 0;
  int fn = 0;

  pix_serializer dut_i (
    .pix_clk(pix_clk), .fast_clk(fast_clk), .rst_n(rst_n), .fall_edge(fall_edge),
    .pwr_dn(pwr_dn), .frame_strb(frame_strb), .pix_data(pix_data),
    .lane_q(lane_q), .clk_lane_q(clk_lane_q));

  // bit 28 selects the capture edge, bits 27:0 are the pixel word
  localparam logic [28:0] VEC [8] = '{
    29'h0_0000001, 29'h0_8000000, 29'h0_FFFFFFF, 29'h1_5555555,
    29'h1_AAAAAAA, 29'h0_1234567, 29'h1_0FEDCBA, 29'h0_7F0007F};

  initial begin fast_clk = 0; forever #(CLK_PERIOD/2) fast_clk = ~fast_clk; end
  initial begin
    pix_clk = 0;
    #(2*CLK_PERIOD) pix_clk = 1;
    forever #(CLK_PERIOD*7/2) pix_clk = ~pix_clk;
  end
  initial begin
    frame_strb = 0;
    forever begin
      @(negedge fast_clk);
      frame_strb = ((fn + 1) % 7 == 0);
      fn++;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wait_load();
    do @(posedge fast_clk); while (!frame_strb);
  endtask

  task automatic get_frame(output logic [27:0] got, output logic [6:0] ck);
    wait_load();
    for (int j = 0; j < 7; j++) begin
      @(negedge fast_clk);
      for (int k = 0; k < 4; k++) got[k*7+j] = lane_q[k];
      ck[j] = clk_lane_q;
    end
  endtask

  task automatic check_frame(input string req, input logic [27:0] exp, input logic [6:0] exp_ck);
    logic [27:0] got;
    logic [6:0] ck;
    get_frame(got, ck);
    for (int k = 0; k < 4; k++)
      chk(req, $sformatf("lane %0d", k), {25'd0, got[k*7 +: 7]}, {25'd0, exp[k*7 +: 7]});
    chk("R5", "clock lane", {25'd0, ck}, {25'd0, exp_ck});
  endtask

  task automatic edge_case(input logic fe);
    fall_edge = fe;
    pix_data = 28'h0A5A5A5;
    repeat (3) wait_load();
    repeat (3) @(negedge fast_clk);
    pix_data = 28'h05A5A5A;
    // change lies between a rising and a falling pixel edge, both before the hold update
    check_frame("R2/R7", fe ? 28'h05A5A5A : 28'h0A5A5A5, CK_SEQ);
  endtask

  initial begin
    rst_n = 0; pwr_dn = 0; fall_edge = 0; pix_data = '0;
    repeat (3) @(negedge fast_clk);
    chk("R1", "lanes in reset", {27'd0, lane_q, clk_lane_q}, 32'd0);
    rst_n = 1;

    for (int v = 0; v < 8; v++) begin
      fall_edge = VEC[v][28];
      pix_data = VEC[v][27:0];
      repeat (3) wait_load();
      check_frame("R3/R4/R6", VEC[v][27:0], CK_SEQ);
    end

    edge_case(1'b0);
    edge_case(1'b1);

    // power-down
    fall_edge = 0;
    pix_data = 28'h3C3C3C3;
    repeat (3) wait_load();
    @(negedge fast_clk);
    pwr_dn = 1;
    repeat (2) wait_load();
    check_frame("R8", 28'h0, 7'h0);
    wait_load();
    @(negedge fast_clk);
    pwr_dn = 0;
    for (int j = 0; j < 6; j++) begin
      @(negedge fast_clk);
      chk("R9", "quiet before reload", {27'd0, lane_q, clk_lane_q}, 32'd0);
    end
    check_frame("R9", 28'h3C3C3C3, CK_SEQ);

    // asynchronous reset mid-frame
    pix_data = 28'h6E6E6E6;
    repeat (3) wait_load();
    repeat (2) @(negedge fast_clk);
    rst_n = 0;
    #1;
    chk("R1", "async reset", {27'd0, lane_q, clk_lane_q}, 32'd0);
    @(negedge fast_clk);
    rst_n = 1;
    repeat (3) wait_load();
    check_frame("R1", 28'h6E6E6E6, CK_SEQ);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule